// File: doc/BRIEF.md
# Serial Converter Readout and Power-Mode Controller

This block is the digital front of a serial converter. It holds each finished result and announces it by pulling the serial data line low. It then presents the result one bit per serial-clock rising edge. The host has no command register. It steers the power mode by how many serial clocks it sends after a data-ready announcement.

A full read takes 32 rising edges: a 24-bit result and then an 8-bit status byte. A burst of exactly eight edges, followed by a quiet serial clock, asks for sleep. Sleep does not begin at once. It starts when the next conversion finishes. In sleep the oscillator enable drops, conversions stop being accepted and the data line stays high. A second eight-edge burst re-enables the oscillator. Normal operation resumes once the oscillator reports ready.

The serial clock and chip select are asynchronous to the master clock. The block brings both into the master clock domain through synchronizer chains and does all edge counting there. After power-on, a start-up counter holds the block quiet for a fixed number of master clock cycles.

Top module: `adc_link_ctrl`

## Requirements
- R1: After reset is released, the block ignores conversion-done strobes for POR_CYCLES master clock cycles and holds sdo_o high. After that it enters normal mode with asleep_o low and osc_en_o high.
- R2: In normal mode, with chip select asserted, a conversion-done strobe captures conv_data_i and drives sdo_o low within 8 master clock cycles.
- R3: After the k-th serial clock rising edge of a read (k = 1..32), sdo_o carries frame bit 32-k. The frame is {result[23:0], status[7:0]}, sent MSB first. When the 32-edge burst goes idle for IDLE_TIMEOUT cycles, sdo_o returns high until the next result.
- R4: Status bit 7 is set when the previous result was still unread at capture. Status bits 6:0 are a capture sequence number that starts at 0 after reset and wraps modulo 128.
- R5: A burst of exactly CMD_EDGES (8) edges, followed by IDLE_TIMEOUT idle cycles while a result is pending, cancels that result (sdo_o high). The next conversion-done strobe then sets asleep_o and clears osc_en_o instead of being captured.
- R6: While asleep, sdo_o stays high with chip select asserted, and conversion-done strobes are ignored.
- R7: While asleep, an 8-edge burst followed by idle raises osc_en_o, and asleep_o stays high until osc_ready_i is seen. Normal mode then resumes, and the next result drives sdo_o low.
- R8: With chip select deasserted, sdo_oe_o is low and any partial edge count is dropped. On reselect, a pending result reads from its MSB again.
- R9: A burst that goes idle with any edge count other than 8 or 32 is discarded. The pending result stays announced (sdo_o low) and no sleep request is made.
- R10: An 8-edge burst when no result is pending does not request sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| csel_n_i | input | 1 | Chip select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock from host, asynchronous |
| conv_done_i | input | 1 | One-cycle strobe: a conversion finished |
| conv_data_i | input | RES_W | Conversion result |
| osc_ready_i | input | 1 | Oscillator stable after wake |
| sdo_o | output | 1 | Serial data / data-ready line |
| sdo_oe_o | output | 1 | Output enable of the serial data line |
| asleep_o | output | 1 | Sleep flag, gates the converter |
| osc_en_o | output | 1 | Oscillator enable |

## Verification
The bench keeps the default 490-cycle start-up count, so it probes both the quiet start-up window and its end. It builds the block with IDLE_TIMEOUT set to 24 and drives the serial clock with 8-cycle half periods. Every edge inside a read is therefore well inside the timeout, while a deliberate pause ends a burst in a few dozen cycles. With these values, full reads, partial bursts of random length, the eight-edge sleep and wake bursts and the deselect case all fit into a few thousand cycles.

// File: rtl/adc_link_pkg.sv
package adc_link_pkg;
  typedef enum logic [1:0] {
    ST_POR   = 2'd0,
    ST_RUN   = 2'd1,
    ST_SLEEP = 2'd2,
    ST_WAKE  = 2'd3
  } link_state_e;
endpackage

// File: rtl/adc_link_sync.sv
module adc_link_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= RST_VAL;
      else     chain[g] <= chain[g-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_link_burst.sv
module adc_link_burst #(
  parameter int READ_EDGES   = 32,
  parameter int CMD_EDGES    = 8,
  parameter int IDLE_TIMEOUT = 32,
  localparam int CNT_W  = $clog2(READ_EDGES + 1),
  localparam int IDLE_W = $clog2(IDLE_TIMEOUT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             rise,
  output logic [CNT_W-1:0] cnt,
  output logic             frame_end,
  output logic             cmd_seen
);
  logic [IDLE_W-1:0] idle;
  logic              armed;

  always_ff @(posedge clk) begin
    frame_end <= 1'b0;
    cmd_seen  <= 1'b0;
    if (rst || clear) begin
      cnt   <= '0;
      idle  <= '0;
      armed <= 1'b0;
    end else if (rise) begin
      idle  <= '0;
      armed <= 1'b1;
      if (cnt != CNT_W'(READ_EDGES)) cnt <= cnt + 1'b1;
    end else if (armed) begin
      if (idle == IDLE_W'(IDLE_TIMEOUT - 1)) begin
        armed     <= 1'b0;
        idle      <= '0;
        cnt       <= '0;
        cmd_seen  <= (cnt == CNT_W'(CMD_EDGES));
        frame_end <= (cnt == CNT_W'(READ_EDGES));
      end else begin
        idle <= idle + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_link_frame.sv
module adc_link_frame #(
  parameter int RES_W  = 24,
  parameter int STAT_W = 8,
  localparam int FRAME_W = RES_W + STAT_W,
  localparam int CNT_W   = $clog2(FRAME_W + 1),
  localparam int IDX_W   = $clog2(FRAME_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [RES_W-1:0]  data,
  input  logic              ovr,
  input  logic [STAT_W-2:0] seq,
  input  logic [CNT_W-1:0]  pos,
  output logic              line
);
  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   rev;

  always_ff @(posedge clk) begin
    if (rst)       frame_q <= '0;
    else if (load) frame_q <= {data, ovr, seq};
  end

  always_comb begin
    rev  = CNT_W'(FRAME_W) - pos;
    line = (pos == '0) ? 1'b0 : frame_q[IDX_W'(rev)];
  end
endmodule

// File: rtl/adc_link_ctrl.sv
module adc_link_ctrl
  import adc_link_pkg::*;
#(
  parameter int RES_W        = 24,
  parameter int STAT_W       = 8,
  parameter int POR_CYCLES   = 490,
  parameter int CMD_EDGES    = 8,
  parameter int IDLE_TIMEOUT = 32,
  parameter int SYNC_STAGES  = 2,
  localparam int FRAME_W = RES_W + STAT_W,
  localparam int CNT_W   = $clog2(FRAME_W + 1),
  localparam int POR_W   = $clog2(POR_CYCLES + 1),
  localparam int SEQ_W   = STAT_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csel_n_i,
  input  logic             sclk_i,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_data_i,
  input  logic             osc_ready_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic             asleep_o,
  output logic             osc_en_o
);
  logic sclk_q, sclk_prev, csel_n_q, sel_q, rise;

  adc_link_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst(rst), .d(sclk_i), .q(sclk_q)
  );
  adc_link_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csel (
    .clk(clk), .rst(rst), .d(csel_n_i), .q(csel_n_q)
  );

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= sclk_q;
  end

  assign sel_q = ~csel_n_q;
  assign rise  = sclk_q & ~sclk_prev;

  link_state_e      state;
  logic [POR_W-1:0] por_cnt;
  logic             ready, sleep_pend;
  logic [SEQ_W-1:0] seq;
  logic             capture, go_sleep;
  logic [CNT_W-1:0] edge_cnt;
  logic             frame_end, cmd_seen, line;

  assign capture  = (state == ST_RUN) && conv_done_i && !sleep_pend;
  assign go_sleep = (state == ST_RUN) && conv_done_i && sleep_pend;

  adc_link_burst #(
    .READ_EDGES(FRAME_W), .CMD_EDGES(CMD_EDGES), .IDLE_TIMEOUT(IDLE_TIMEOUT)
  ) u_burst (
    .clk(clk), .rst(rst), .clear(~sel_q | capture), .rise(rise),
    .cnt(edge_cnt), .frame_end(frame_end), .cmd_seen(cmd_seen)
  );

  adc_link_frame #(.RES_W(RES_W), .STAT_W(STAT_W)) u_frame (
    .clk(clk), .rst(rst), .load(capture), .data(conv_data_i),
    .ovr(ready), .seq(seq), .pos(edge_cnt), .line(line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_POR;
      por_cnt    <= '0;
      ready      <= 1'b0;
      sleep_pend <= 1'b0;
      seq        <= '0;
    end else begin
      unique case (state)
        ST_POR: begin
          if (por_cnt == POR_W'(POR_CYCLES - 1)) state <= ST_RUN;
          else por_cnt <= por_cnt + 1'b1;
        end
        ST_RUN: begin
          if (go_sleep) begin
            state      <= ST_SLEEP;
            sleep_pend <= 1'b0;
            ready      <= 1'b0;
          end else if (capture) begin
            ready <= 1'b1;
            seq   <= seq + 1'b1;
          end else if (cmd_seen && ready) begin
            sleep_pend <= 1'b1;
            ready      <= 1'b0;
          end else if (frame_end) begin
            ready <= 1'b0;
          end
        end
        ST_SLEEP: if (cmd_seen) state <= ST_WAKE;
        ST_WAKE:  if (osc_ready_i) state <= ST_RUN;
        default:  state <= ST_POR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_o    <= 1'b1;
      sdo_oe_o <= 1'b0;
    end else begin
      sdo_oe_o <= sel_q;
      if (sel_q && state == ST_RUN && ready) sdo_o <= line;
      else                                    sdo_o <= 1'b1;
    end
  end

  assign asleep_o = (state == ST_SLEEP) || (state == ST_WAKE);
  assign osc_en_o = (state != ST_SLEEP);
endmodule

// File: rtl/adc_link_checker.sv
module adc_link_checker #(
  parameter int FRAME_W = 32,
  parameter int CNT_W   = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             in_por,
  input logic             sel_q,
  input logic             conv_done_i,
  input logic             osc_ready_i,
  input logic [CNT_W-1:0] pos,
  input logic             sdo_o,
  input logic             sdo_oe_o,
  input logic             asleep_o,
  input logic             osc_en_o
);
  AST_POR_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    in_por |-> (sdo_o && !asleep_o)); // R1
  AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    pos <= CNT_W'(FRAME_W)); // R3
  AST_OSC_OFF_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    !osc_en_o |-> asleep_o); // R5
  AST_SLEEP_AT_RESULT: assert property (@(posedge clk) disable iff (rst)
    $rose(asleep_o) |-> $past(conv_done_i)); // R5
  AST_SLEEP_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (asleep_o && sdo_oe_o) |-> sdo_o); // R6
  AST_WAKE_AFTER_OSC: assert property (@(posedge clk) disable iff (rst)
    $fell(asleep_o) |-> $past(osc_ready_i)); // R7
  AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (rst)
    !sel_q |=> !sdo_oe_o); // R8
endmodule

bind adc_link_ctrl adc_link_checker #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .in_por(state == adc_link_pkg::ST_POR), .sel_q(sel_q),
  .conv_done_i(conv_done_i), .osc_ready_i(osc_ready_i), .pos(edge_cnt),
  .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .asleep_o(asleep_o), .osc_en_o(osc_en_o)
);

// File: tb/adc_link_ctrl_bench.sv
module adc_link_ctrl_bench;
  localparam int TMO  = 24;
  localparam int HALF = 8;

  logic clk = 1'b0, rst = 1'b1, csel_n = 1'b0, sclk = 1'b0;
  logic conv_done = 1'b0, osc_ready = 1'b0;
  logic [23:0] conv_data = '0;
  logic sdo, sdo_oe, asleep, osc_en;

  int n_cmp = 0, n_bad = 0, exp_seq = 0;
  bit exp_ready = 1'b0;
  logic [31:0] exp_frame = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adc_link_ctrl #(.IDLE_TIMEOUT(TMO)) u_adc_link_ctrl (
    .clk(clk), .rst(rst), .csel_n_i(csel_n), .sclk_i(sclk),
    .conv_done_i(conv_done), .conv_data_i(conv_data), .osc_ready_i(osc_ready),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .asleep_o(asleep), .osc_en_o(osc_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] frame_of(input logic [23:0] d, input bit ovr, input int sq);
    logic [6:0] s = 7'(sq);
    return {d, ovr, s};
  endfunction

  task automatic strobe(input logic [23:0] d);
    @(negedge clk);
    conv_done = 1'b1; conv_data = d;
    @(negedge clk);
    conv_done = 1'b0;
    tick(8);
  endtask

  task automatic capture(input logic [23:0] d);
    exp_frame = frame_of(d, exp_ready, exp_seq);
    exp_seq++;
    exp_ready = 1'b1;
    strobe(d);
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; tick(HALF);
      sclk = 1'b0; tick(HALF);
    end
  endtask

  task automatic burst(input int n);
    edges(n);
    tick(TMO + 10);
  endtask

  task automatic read_check(input string req);
    logic [31:0] got = '0;
    for (int i = 0; i < 32; i++) begin
      sclk = 1'b1; tick(HALF);
      got = {got[30:0], sdo};
      sclk = 1'b0; tick(HALF);
    end
    chk({req, " frame"}, got, exp_frame);
    tick(TMO + 10);
    chk("R3 line high after read", {31'd0, sdo}, 32'd1);
    exp_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int n;
    r = $urandom(32'h1d2c3b4a);
    tick(5);
    rst = 1'b0;
    tick(10);
    chk("R1 reset oe", {31'd0, sdo_oe}, 32'd1);
    chk("R1 reset sdo", {31'd0, sdo}, 32'd1);
    chk("R1 reset asleep", {31'd0, asleep}, 32'd0);
    chk("R1 reset osc_en", {31'd0, osc_en}, 32'd1);
    tick(80);
    strobe(24'h123456);
    chk("R1 early strobe ignored", {31'd0, sdo}, 32'd1);
    tick(370);
    strobe(24'h654321);
    chk("R1 late strobe ignored", {31'd0, sdo}, 32'd1);
    tick(30);

    capture(24'hA5C3F0);
    chk("R2 ready low", {31'd0, sdo}, 32'd0);
    read_check("R3 R4 first");

    capture(24'h0F0F0F);
    capture(24'hF00001);
    read_check("R4 overrun");

    for (int k = 0; k < 8; k++) begin
      r = $urandom;
      capture(r[23:0]);
      chk("R2 ready low random", {31'd0, sdo}, 32'd0);
      if ($urandom_range(0, 1) == 1) begin
        n = $urandom_range(1, 31);
        if (n == 8) n = 9;
        burst(n);
        chk("R9 partial burst keeps ready", {31'd0, sdo}, 32'd0);
        chk("R9 no sleep", {31'd0, asleep}, 32'd0);
      end
      read_check("R3 random");
    end

    capture(24'hC0FFEE);
    edges(5);
    csel_n = 1'b1; tick(10);
    chk("R8 deselect hiz", {31'd0, sdo_oe}, 32'd0);
    csel_n = 1'b0; tick(10);
    chk("R8 reselect oe", {31'd0, sdo_oe}, 32'd1);
    chk("R8 reselect ready", {31'd0, sdo}, 32'd0);
    read_check("R8 restart");

    burst(8);
    capture(24'h135791);
    chk("R10 not asleep", {31'd0, asleep}, 32'd0);
    chk("R10 ready low", {31'd0, sdo}, 32'd0);
    read_check("R10 frame");

    capture(24'h2468AC);
    burst(8);
    exp_ready = 1'b0;
    chk("R5 request cancels ready", {31'd0, sdo}, 32'd1);
    chk("R5 deferred", {31'd0, asleep}, 32'd0);
    strobe(24'hDEAD00);
    chk("R5 asleep", {31'd0, asleep}, 32'd1);
    chk("R5 osc off", {31'd0, osc_en}, 32'd0);
    chk("R6 line high", {31'd0, sdo}, 32'd1);
    strobe(24'hBEEF00);
    chk("R6 strobe ignored", {31'd0, sdo}, 32'd1);
    csel_n = 1'b1; tick(10);
    chk("R8 deselect in sleep", {31'd0, sdo_oe}, 32'd0);
    csel_n = 1'b0; tick(10);

    burst(8);
    chk("R7 osc on", {31'd0, osc_en}, 32'd1);
    tick(20);
    chk("R7 waits osc", {31'd0, asleep}, 32'd1);
    osc_ready = 1'b1; tick(8);
    chk("R7 awake", {31'd0, asleep}, 32'd0);
    chk("R7 no data yet", {31'd0, sdo}, 32'd1);
    osc_ready = 1'b0;
    capture(24'h7E57ED);
    chk("R7 new result ready", {31'd0, sdo}, 32'd0);
    read_check("R7 frame");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule